// File: doc/BRIEF.md
# Parallel DAC Bus Command Sequencer

This block sits on the host side of a sixteen-channel, eight-bit voltage DAC with a level-latched parallel interface. It takes one command at a time from a simple valid/ready port and turns it into the pin sequence the converter needs. The pins are a channel address, a data bus with separate in, out and driver-enable lines, an active-low select, a read/not-write line, an active-low enable strobe and an active-low load strobe. Each converter channel has an input register and a DAC register behind it.

Five commands are supported. A plain write loads one input register. A write-with-update loads one input register and copies all input registers into the DAC registers with the same strobe. A global load copies all input registers into the DAC registers. A readback returns one input register. A ramp repeatedly writes a stepping code to one channel. Every minimum interval of the interface is a parameter in nanoseconds. The block converts each one to whole clock cycles, rounding up, so no pulse, setup or access window is shorter than required. A one-cycle done pulse reports completion, and the read value comes with it.

Top module: `dacbus_seq`

## Requirements
- R1: While reset is applied and in the first cycle after it, select, enable and load are high (inactive), the data driver is off, done is low and ready is high.
- R2: Op code 0 (write) drives select and read/not-write low, the address equal to the channel and the data on the bus. It then pulses enable low with load held high. Address and data stay constant while enable is low. Done arrives C_SET + C_STB + C_HLD cycles after the command is accepted.
- R3: Op code 1 (write with update) behaves as R2, but load goes low together with enable, so every DAC register takes its input register's value. Load is never low while enable is high.
- R4: Op code 3 (global load) keeps select high and pulses enable and load low together. No input register changes. Done arrives C_SET + C_ENL + C_ENH cycles after acceptance.
- R5: Op code 2 (read) turns the data driver off one cycle before read/not-write rises, and the driver is never on while read/not-write is high. The bus is sampled after C_ACC cycles of select-low access. Done arrives 1 + C_ACC + C_REL cycles after acceptance.
- R6: Op code 4 (ramp) writes with update, as in R3. The codes are 0, then the previous code plus the step taken from the data input, where a step of 0 counts as 1. A code whose sum would exceed 255 restarts at 0.
- R7: A ramp performs N writes, where N is the length input and a length of 0 counts as 1. The writes are separated by G idle cycles, where G is the gap input, and done arrives N*(C_SET+C_STB+C_HLD) + (N-1)*G cycles after acceptance.
- R8: A command is accepted only in a cycle where ready is high. A valid command presented while the block is busy is ignored.
- R9: Done is high for exactly one cycle per accepted command, and ready is high in that cycle. For a read, the readback value is on rd_data while done is high.
- R10: Each interval is ceil(ns / CLK_NS) cycles, with a minimum of 1. C_STB is the larger of the enable-low and data-setup intervals, and C_HLD is the larger of the enable-high and data-hold intervals. C_ACC is the largest of the address-to-data, read/not-write-to-bus and select-to-data delays. Enable is never low for fewer than C_ENL cycles or high between pulses for fewer than C_ENH cycles.
- R11: Op codes 5 to 7 give done in the cycle after acceptance with no activity on the bus pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Command code (see R2 to R7, R11) |
| cmd_chan | input | CH_W | Target channel |
| cmd_data | input | DW | Write data, or ramp step |
| cmd_len | input | LEN_W | Ramp write count |
| cmd_gap | input | GAP_W | Idle cycles between ramp writes |
| cmd_ready | output | 1 | Sequencer idle, command may be accepted |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DW | Readback value |
| dac_addr | output | CH_W | Channel address pins |
| dac_dout | output | DW | Data bus, value driven |
| dac_din | input | DW | Data bus, value sensed |
| dac_doe | output | 1 | Data bus driver enable |
| dac_rw | output | 1 | High for read, low for write |
| dac_cs_n | output | 1 | Select, active low |
| dac_en_n | output | 1 | Enable strobe, active low |
| dac_ld_n | output | 1 | DAC register load strobe, active low |

## Verification
The checks on address and data stability assume that a command is accepted only when ready is high, so no field of the command register changes during a strobe. The bench therefore issues each command only after the previous done pulse, except in one directed case that holds valid high throughout a busy write. The readback check assumes the bus value from the converter is settled by the end of the access window. The bench's behavioural converter drives the input register value as soon as select is low with read/not-write high. Random commands draw only the five defined codes and the undefined ones, with short ramp lengths and gaps so that the run stays brief.

// File: rtl/dacbus_pkg.sv
`timescale 1ns/1ps
package dacbus_pkg;

    typedef enum logic [2:0] {
        OP_WRITE = 3'd0,
        OP_WRUPD = 3'd1,
        OP_READ  = 3'd2,
        OP_LOAD  = 3'd3,
        OP_RAMP  = 3'd4
    } op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WSET,
        ST_WSTB,
        ST_WHLD,
        ST_GAP,
        ST_LSET,
        ST_LSTB,
        ST_LHLD,
        ST_RTRN,
        ST_RACC,
        ST_RREL
    } state_e;

    // Interval in ns to whole cycles, rounded up, never below one cycle.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int max_i(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dacbus_timer.sv
`timescale 1ns/1ps
// Phase timer: loaded with (cycles - 1) on entry to a phase, counts to zero.
module dacbus_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/dacbus_ramp_step.sv
`timescale 1ns/1ps
// Next ramp code: add step (zero treated as one), restart at zero past full scale.
module dacbus_ramp_step #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] cur,
    input  logic [DW-1:0] step,
    output logic [DW-1:0] nxt
);
    logic [DW-1:0] inc;
    logic [DW:0]   sum;

    always_comb begin
        inc = (step == '0) ? DW'(1) : step;
        sum = {1'b0, cur} + {1'b0, inc};
        nxt = sum[DW] ? '0 : sum[DW-1:0];
    end
endmodule

// File: rtl/dacbus_pin_dec.sv
`timescale 1ns/1ps
// Bus pin levels for each sequencer phase.
module dacbus_pin_dec
    import dacbus_pkg::*;
#(
    parameter int CH_W = 4,
    parameter int DW   = 8
) (
    input  state_e          st,
    input  logic            upd,
    input  logic [CH_W-1:0] chan,
    input  logic [DW-1:0]   data,
    output logic [CH_W-1:0] addr,
    output logic [DW-1:0]   dout,
    output logic            doe,
    output logic            rw,
    output logic            cs_n,
    output logic            en_n,
    output logic            ld_n
);
    always_comb begin
        addr = chan;
        dout = data;
        doe  = 1'b0;
        rw   = 1'b0;
        cs_n = 1'b1;
        en_n = 1'b1;
        ld_n = 1'b1;
        case (st)
            ST_WSET, ST_WHLD: begin
                cs_n = 1'b0;
                doe  = 1'b1;
            end
            ST_WSTB: begin
                cs_n = 1'b0;
                doe  = 1'b1;
                en_n = 1'b0;
                ld_n = !upd;
            end
            ST_LSTB: begin
                en_n = 1'b0;
                ld_n = 1'b0;
            end
            ST_RACC: begin
                cs_n = 1'b0;
                rw   = 1'b1;
            end
            ST_RREL: begin
                rw   = 1'b1;
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/dacbus_seq.sv
`timescale 1ns/1ps
module dacbus_seq
    import dacbus_pkg::*;
#(
    parameter int CLK_NS    = 5,
    parameter int CH_W      = 4,
    parameter int DW        = 8,
    parameter int LEN_W     = 8,
    parameter int GAP_W     = 8,
    parameter int T_ENL_NS  = 40,
    parameter int T_ENH_NS  = 40,
    parameter int T_DS_NS   = 10,
    parameter int T_DH_NS   = 0,
    parameter int T_AS_NS   = 0,
    parameter int T_AD_NS   = 160,
    parameter int T_RWD_NS  = 120,
    parameter int T_CSD_NS  = 150,
    parameter int T_BUSZ_NS = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [CH_W-1:0]  cmd_chan,
    input  logic [DW-1:0]    cmd_data,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic [GAP_W-1:0] cmd_gap,
    output logic             cmd_ready,
    output logic             done,
    output logic [DW-1:0]    rd_data,
    output logic [CH_W-1:0]  dac_addr,
    output logic [DW-1:0]    dac_dout,
    input  logic [DW-1:0]    dac_din,
    output logic             dac_doe,
    output logic             dac_rw,
    output logic             dac_cs_n,
    output logic             dac_en_n,
    output logic             dac_ld_n
);
    localparam int C_SET = ns_to_cyc(T_AS_NS, CLK_NS);
    localparam int C_ENL = ns_to_cyc(T_ENL_NS, CLK_NS);
    localparam int C_ENH = ns_to_cyc(T_ENH_NS, CLK_NS);
    localparam int C_STB = max_i(C_ENL, ns_to_cyc(T_DS_NS, CLK_NS));
    localparam int C_HLD = max_i(C_ENH, ns_to_cyc(T_DH_NS, CLK_NS));
    localparam int C_ACC = max_i(ns_to_cyc(T_AD_NS, CLK_NS),
                           max_i(ns_to_cyc(T_RWD_NS, CLK_NS), ns_to_cyc(T_CSD_NS, CLK_NS)));
    localparam int C_REL = ns_to_cyc(T_BUSZ_NS, CLK_NS);
    localparam int C_MAX = max_i(max_i(max_i(C_SET, C_STB), max_i(C_HLD, C_ACC)), C_REL);
    localparam int CNT_W = max_i($clog2(C_MAX + 1), GAP_W);

    typedef struct packed {
        state_e            st;
        logic              upd;
        logic              ramp;
        logic [CH_W-1:0]   chan;
        logic [DW-1:0]     data;
        logic [DW-1:0]     step;
        logic [LEN_W-1:0]  rem;
        logic [GAP_W-1:0]  gap;
        logic              done;
        logic [DW-1:0]     rdat;
    } core_t;

    typedef struct packed {
        logic [CH_W-1:0] addr;
        logic [DW-1:0]   dout;
        logic            doe;
        logic            rw;
        logic            cs_n;
        logic            en_n;
        logic            ld_n;
    } pins_t;

    core_t core_d, core_q;
    pins_t pins_d, pins_q;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;
    logic [DW-1:0]    ramp_nxt;

    logic [CH_W-1:0]  p_addr;
    logic [DW-1:0]    p_dout;
    logic             p_doe, p_rw, p_cs_n, p_en_n, p_ld_n;

    dacbus_timer #(.CNT_W(CNT_W)) tmr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .val   (tmr_val),
        .zero  (tmr_zero)
    );

    dacbus_ramp_step #(.DW(DW)) ramp_i (
        .cur  (core_q.data),
        .step (core_q.step),
        .nxt  (ramp_nxt)
    );

    // Sequencer: next phase, command fields and timer load.
    always_comb begin
        core_d      = core_q;
        core_d.done = 1'b0;
        tmr_load    = 1'b0;
        tmr_val     = '0;
        case (core_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    core_d.chan = cmd_chan;
                    core_d.data = cmd_data;
                    core_d.upd  = 1'b0;
                    core_d.ramp = 1'b0;
                    case (cmd_op)
                        OP_WRITE: begin
                            core_d.st = ST_WSET;
                            tmr_load  = 1'b1;
                            tmr_val   = CNT_W'(C_SET - 1);
                        end
                        OP_WRUPD: begin
                            core_d.upd = 1'b1;
                            core_d.st  = ST_WSET;
                            tmr_load   = 1'b1;
                            tmr_val    = CNT_W'(C_SET - 1);
                        end
                        OP_READ: begin
                            core_d.st = ST_RTRN;
                            tmr_load  = 1'b1;
                            tmr_val   = '0;
                        end
                        OP_LOAD: begin
                            core_d.st = ST_LSET;
                            tmr_load  = 1'b1;
                            tmr_val   = CNT_W'(C_SET - 1);
                        end
                        OP_RAMP: begin
                            core_d.ramp = 1'b1;
                            core_d.upd  = 1'b1;
                            core_d.data = '0;
                            core_d.step = cmd_data;
                            core_d.rem  = cmd_len;
                            core_d.gap  = cmd_gap;
                            core_d.st   = ST_WSET;
                            tmr_load    = 1'b1;
                            tmr_val     = CNT_W'(C_SET - 1);
                        end
                        default: begin
                            core_d.done = 1'b1;
                        end
                    endcase
                end
            end
            ST_WSET: begin
                if (tmr_zero) begin
                    core_d.st = ST_WSTB;
                    tmr_load  = 1'b1;
                    tmr_val   = CNT_W'(C_STB - 1);
                end
            end
            ST_WSTB: begin
                if (tmr_zero) begin
                    core_d.st = ST_WHLD;
                    tmr_load  = 1'b1;
                    tmr_val   = CNT_W'(C_HLD - 1);
                end
            end
            ST_WHLD: begin
                if (tmr_zero) begin
                    if (core_q.ramp && (core_q.rem > LEN_W'(1))) begin
                        core_d.rem  = core_q.rem - LEN_W'(1);
                        core_d.data = ramp_nxt;
                        tmr_load    = 1'b1;
                        if (core_q.gap == '0) begin
                            core_d.st = ST_WSET;
                            tmr_val   = CNT_W'(C_SET - 1);
                        end else begin
                            core_d.st = ST_GAP;
                            tmr_val   = CNT_W'(core_q.gap - GAP_W'(1));
                        end
                    end else begin
                        core_d.st   = ST_IDLE;
                        core_d.done = 1'b1;
                    end
                end
            end
            ST_GAP: begin
                if (tmr_zero) begin
                    core_d.st = ST_WSET;
                    tmr_load  = 1'b1;
                    tmr_val   = CNT_W'(C_SET - 1);
                end
            end
            ST_LSET: begin
                if (tmr_zero) begin
                    core_d.st = ST_LSTB;
                    tmr_load  = 1'b1;
                    tmr_val   = CNT_W'(C_ENL - 1);
                end
            end
            ST_LSTB: begin
                if (tmr_zero) begin
                    core_d.st = ST_LHLD;
                    tmr_load  = 1'b1;
                    tmr_val   = CNT_W'(C_ENH - 1);
                end
            end
            ST_LHLD: begin
                if (tmr_zero) begin
                    core_d.st   = ST_IDLE;
                    core_d.done = 1'b1;
                end
            end
            ST_RTRN: begin
                if (tmr_zero) begin
                    core_d.st = ST_RACC;
                    tmr_load  = 1'b1;
                    tmr_val   = CNT_W'(C_ACC - 1);
                end
            end
            ST_RACC: begin
                if (tmr_zero) begin
                    core_d.rdat = dac_din;
                    core_d.st   = ST_RREL;
                    tmr_load    = 1'b1;
                    tmr_val     = CNT_W'(C_REL - 1);
                end
            end
            ST_RREL: begin
                if (tmr_zero) begin
                    core_d.st   = ST_IDLE;
                    core_d.done = 1'b1;
                end
            end
            default: begin
                core_d.st = ST_IDLE;
            end
        endcase
    end

    // Pin levels follow the next phase so they change on the same edge.
    dacbus_pin_dec #(.CH_W(CH_W), .DW(DW)) dec_i (
        .st   (core_d.st),
        .upd  (core_d.upd),
        .chan (core_d.chan),
        .data (core_d.data),
        .addr (p_addr),
        .dout (p_dout),
        .doe  (p_doe),
        .rw   (p_rw),
        .cs_n (p_cs_n),
        .en_n (p_en_n),
        .ld_n (p_ld_n)
    );

    always_comb begin
        pins_d.addr = p_addr;
        pins_d.dout = p_dout;
        pins_d.doe  = p_doe;
        pins_d.rw   = p_rw;
        pins_d.cs_n = p_cs_n;
        pins_d.en_n = p_en_n;
        pins_d.ld_n = p_ld_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q      <= '0;
            core_q.st   <= ST_IDLE;
            pins_q      <= '0;
            pins_q.cs_n <= 1'b1;
            pins_q.en_n <= 1'b1;
            pins_q.ld_n <= 1'b1;
        end else begin
            core_q <= core_d;
            pins_q <= pins_d;
        end
    end

    assign cmd_ready = (core_q.st == ST_IDLE);
    assign done      = core_q.done;
    assign rd_data   = core_q.rdat;
    assign dac_addr  = pins_q.addr;
    assign dac_dout  = pins_q.dout;
    assign dac_doe   = pins_q.doe;
    assign dac_rw    = pins_q.rw;
    assign dac_cs_n  = pins_q.cs_n;
    assign dac_en_n  = pins_q.en_n;
    assign dac_ld_n  = pins_q.ld_n;
endmodule

// File: rtl/dacbus_seq_chk.sv
`timescale 1ns/1ps
module dacbus_seq_chk #(
    parameter int CH_W  = 4,
    parameter int DW    = 8,
    parameter int C_ENL = 8,
    parameter int C_ENH = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_valid,
    input logic [2:0]      cmd_op,
    input logic            cmd_ready,
    input logic            done,
    input logic [CH_W-1:0] dac_addr,
    input logic [DW-1:0]   dac_dout,
    input logic            dac_doe,
    input logic            dac_rw,
    input logic            dac_cs_n,
    input logic            dac_en_n,
    input logic            dac_ld_n
);
    logic [15:0] lo_d, lo_q, hi_d, hi_q;

    // Run lengths of enable low and enable high, saturating.
    always_comb begin
        lo_d = dac_en_n ? 16'd0 : ((lo_q == 16'hFFFF) ? lo_q : lo_q + 16'd1);
        hi_d = !dac_en_n ? 16'd0 : ((hi_q == 16'hFFFF) ? hi_q : hi_q + 16'd1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= 16'd0;
            hi_q <= 16'hFFFF;
        end else begin
            lo_q <= lo_d;
            hi_q <= hi_d;
        end
    end

    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dac_cs_n && dac_en_n && dac_ld_n && !dac_doe && cmd_ready && !done));

    p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!dac_en_n && $past(!dac_en_n)) |-> $stable(dac_addr));

    p_dout_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!dac_en_n && !dac_cs_n && $past(!dac_en_n)) |-> $stable(dac_dout));

    p_ld_with_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_ld_n |-> !dac_en_n);

    p_load_unselected_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!dac_en_n && dac_cs_n) |-> !dac_ld_n);

    p_no_contention_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(dac_doe && dac_rw));

    p_turnaround_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_rw) |-> $past(!dac_doe));

    p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready && cmd_valid && (cmd_op <= 3'd4)) |=> !cmd_ready);

    p_done_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cmd_ready);

    p_en_low_min_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_en_n) |-> (lo_q >= 16'(C_ENL)));

    p_en_high_min_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_en_n) |-> (hi_q >= 16'(C_ENH)));
endmodule

bind dacbus_seq dacbus_seq_chk #(
    .CH_W  (CH_W),
    .DW    (DW),
    .C_ENL (C_ENL),
    .C_ENH (C_ENH)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_ready (cmd_ready),
    .done      (done),
    .dac_addr  (dac_addr),
    .dac_dout  (dac_dout),
    .dac_doe   (dac_doe),
    .dac_rw    (dac_rw),
    .dac_cs_n  (dac_cs_n),
    .dac_en_n  (dac_en_n),
    .dac_ld_n  (dac_ld_n)
);

// File: tb/dacbus_seq_tb_top.sv
`timescale 1ns/1ps
module dacbus_seq_tb_top;
    // Bench-side interval conversion, from the requirement text.
    function automatic int cyc(input int ns);
        int c;
        c = (ns + 4) / 5;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int B_SET = cyc(0);
    localparam int B_ENL = cyc(40);
    localparam int B_ENH = cyc(40);
    localparam int B_STB = mx(cyc(40), cyc(10));
    localparam int B_HLD = mx(cyc(40), cyc(0));
    localparam int B_ACC = mx(cyc(160), mx(cyc(120), cyc(150)));
    localparam int B_REL = cyc(30);
    localparam int B_WR  = B_SET + B_STB + B_HLD;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [3:0] cmd_chan = 4'd0;
    logic [7:0] cmd_data = 8'd0;
    logic [7:0] cmd_len = 8'd0;
    logic [7:0] cmd_gap = 8'd0;
    logic       cmd_ready, done;
    logic [7:0] rd_data;
    logic [3:0] dac_addr;
    logic [7:0] dac_dout, dac_din;
    logic       dac_doe, dac_rw, dac_cs_n, dac_en_n, dac_ld_n;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    dacbus_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_chan(cmd_chan), .cmd_data(cmd_data), .cmd_len(cmd_len), .cmd_gap(cmd_gap),
        .cmd_ready(cmd_ready), .done(done), .rd_data(rd_data),
        .dac_addr(dac_addr), .dac_dout(dac_dout), .dac_din(dac_din), .dac_doe(dac_doe),
        .dac_rw(dac_rw), .dac_cs_n(dac_cs_n), .dac_en_n(dac_en_n), .dac_ld_n(dac_ld_n)
    );

    // Behavioural converter logic: level-sensitive input and DAC registers.
    logic [7:0] mdl_in  [16];
    logic [7:0] mdl_dac [16];
    logic [7:0] exp_in  [16];
    logic [7:0] exp_dac [16];

    initial begin
        for (int i = 0; i < 16; i++) begin
            mdl_in[i] = 8'd0; mdl_dac[i] = 8'd0; exp_in[i] = 8'd0; exp_dac[i] = 8'd0;
        end
    end

    always @(posedge clk) begin
        if (!dac_cs_n && !dac_rw && !dac_en_n) mdl_in[dac_addr] = dac_dout;
        if (!dac_en_n && !dac_ld_n)
            for (int i = 0; i < 16; i++) mdl_dac[i] = mdl_in[i];
    end

    assign dac_din = (!dac_cs_n && dac_rw) ? mdl_in[dac_addr] : 8'h00;

    // Shortest enable-low run seen on the pins.
    int lo_run = 0;
    int lo_min = 1000;
    always @(negedge clk) begin
        if (rst_n && !dac_en_n) lo_run++;
        else begin
            if (lo_run > 0 && lo_run < lo_min) lo_min = lo_run;
            lo_run = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic logic [7:0] ramp_nx(input logic [7:0] c, input logic [7:0] s);
        int inc, sum;
        inc = (s == 8'd0) ? 1 : int'(s);
        sum = int'(c) + inc;
        return (sum > 255) ? 8'd0 : 8'(sum);
    endfunction

    function automatic int exp_lat(input int op, input int len, input int gap);
        int n;
        case (op)
            0, 1: return B_WR;
            2:    return 1 + B_ACC + B_REL;
            3:    return B_SET + B_ENL + B_ENH;
            4: begin
                n = (len == 0) ? 1 : len;
                return n * B_WR + (n - 1) * gap;
            end
            default: return 0;
        endcase
    endfunction

    task automatic cmp_regs(input string req);
        int bad;
        int idx;
        bad = 0; idx = 0;
        for (int i = 0; i < 16; i++)
            if (mdl_in[i] !== exp_in[i] || mdl_dac[i] !== exp_dac[i]) begin
                if (bad == 0) idx = i;
                bad++;
            end
        chk(bad == 0, req, int'(mdl_in[idx]) * 256 + int'(mdl_dac[idx]),
            int'(exp_in[idx]) * 256 + int'(exp_dac[idx]));
    endtask

    task automatic run_cmd(input int op, input int ch, input int d, input int len,
                           input int gap, output int lat);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'(op); cmd_chan = 4'(ch); cmd_data = 8'(d);
        cmd_len = 8'(len); cmd_gap = 8'(gap);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        lat = 0;
        while (!done && lat < 3000) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
    endtask

    task automatic do_cmd(input int op, input int ch, input int d, input int len, input int gap);
        int lat;
        logic [7:0] code;
        int n;
        string tag;
        run_cmd(op, ch, d, len, gap, lat);
        case (op)
            0: begin exp_in[ch] = 8'(d); tag = "R2"; end
            1: begin exp_in[ch] = 8'(d); for (int i = 0; i < 16; i++) exp_dac[i] = exp_in[i]; tag = "R3"; end
            2: begin chk(rd_data == exp_in[ch], "R5 R9 readback", int'(rd_data), int'(exp_in[ch])); tag = "R5"; end
            3: begin for (int i = 0; i < 16; i++) exp_dac[i] = exp_in[i]; tag = "R4"; end
            4: begin
                code = 8'd0;
                n = (len == 0) ? 1 : len;
                for (int k = 0; k < n; k++) begin
                    exp_in[ch] = code;
                    for (int i = 0; i < 16; i++) exp_dac[i] = exp_in[i];
                    if (k < n - 1) code = ramp_nx(code, 8'(d));
                end
                tag = "R6 R7";
            end
            default: tag = "R11";
        endcase
        chk(lat == exp_lat(op, len, gap), {tag, " latency"}, lat, exp_lat(op, len, gap));
        cmp_regs({tag, " registers"});
        @(negedge clk);
        chk(!done && cmd_ready, "R9 done one cycle", int'(done), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int lat;
        int dn;
        int op;
        void'($urandom(32'd7341));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(dac_cs_n && dac_en_n && dac_ld_n && !dac_doe && !done && cmd_ready,
            "R1 during reset", {dac_cs_n, dac_en_n, dac_ld_n, dac_doe, done, cmd_ready}, 6'b111001);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(dac_cs_n && dac_en_n && dac_ld_n && !dac_doe && !done && cmd_ready,
            "R1 after reset", {dac_cs_n, dac_en_n, dac_ld_n, dac_doe, done, cmd_ready}, 6'b111001);

        // Directed: boundary channels, plain write leaves DAC registers alone (R2)
        do_cmd(0, 0, 8'hA5, 0, 0);
        do_cmd(0, 15, 8'h5A, 0, 0);
        do_cmd(3, 0, 0, 0, 0);            // R4 global load
        do_cmd(2, 15, 0, 0, 0);           // R5 read highest channel
        do_cmd(2, 0, 0, 0, 0);
        do_cmd(1, 7, 8'hFF, 0, 0);        // R3 write with update
        do_cmd(4, 3, 8'h80, 4, 2);        // R6 wrap at full scale
        do_cmd(4, 9, 8'hFF, 3, 0);        // R6 step 255, no gap
        do_cmd(4, 12, 8'h00, 3, 5);       // R6 zero step counts as one
        do_cmd(4, 5, 8'h10, 0, 3);        // R7 length zero is one write
        do_cmd(6, 2, 8'h33, 0, 0);        // R11 undefined code

        // R8: valid held during a busy write is ignored
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd0; cmd_chan = 4'd4; cmd_data = 8'h11;
        @(posedge clk); @(negedge clk);
        cmd_chan = 4'd6; cmd_data = 8'h22; cmd_op = 3'd1;
        repeat (5) @(negedge clk);
        cmd_valid = 1'b0;
        dn = 0;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (done) dn++;
        end
        exp_in[4] = 8'h11;
        chk(dn == 1, "R8 single completion", dn, 1);
        chk(mdl_in[6] == exp_in[6], "R8 busy command ignored", int'(mdl_in[6]), int'(exp_in[6]));
        cmp_regs("R8 registers");

        // Random mix
        for (int it = 0; it < 60; it++) begin
            op = int'($urandom_range(0, 5));
            if (op == 5) op = int'($urandom_range(5, 7));
            do_cmd(op, int'($urandom_range(0, 15)), int'($urandom_range(0, 255)),
                   int'($urandom_range(0, 6)), int'($urandom_range(0, 4)));
        end

        // R10: shortest enable-low pulse on the pins
        chk(lo_min >= B_ENL, "R10 enable low width", lo_min, B_ENL);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule